// File: doc/BRIEF.md
# Pixel Quench Sequencer

This controller steps the switches of a single Geiger-mode photodiode pixel through its detection cycle. While armed it watches a thresholded avalanche-sense input. When that input fires, it closes the quench switch and starts a detection pulse in the same cycle. It then waits out a programmable hold-off, opens the quench switch and closes the reset switch. It keeps the reset switch closed until a comparator flag reports that the node has recovered, and then re-arms. The sense path is masked throughout the quench, hold-off and reset phases, so echoes of the quench edge cannot start a second event.

An external gate level takes priority over everything else. While the gate is low the pixel is held quenched and sense events go nowhere. When the gate comes back high, the controller runs a complete reset phase before it re-arms. Neither gate edge produces a detection pulse. The detection pulse has a nominal width set by a parameter. It is cut short so that it always ends by the time the pixel re-arms, or as soon as the gate forces a quench. A watchdog raises a sticky fault if a reset phase runs too long without the recovery flag.

Top module: `pixel_quench_seq`

## Requirements
- R1: While rst_n is low: quench_en_o=1, reset_en_o=0, sense_en_o=0, det_pulse_o=0, fault_o=0. After release, the controller passes through a reset phase before arming.
- R2: A clock edge that samples sense_i=1 with the pixel armed (sense_en_o=1) and gate_i=1 starts the quench phase in the following cycle. In that cycle quench_en_o=1, sense_en_o=0 and det_pulse_o rises.
- R3: The quench/hold-off phase lasts max(H,1) cycles, where H is holdoff_i sampled at the detecting edge. A value of 0 gives one cycle.
- R4: After hold-off, quench_en_o drops and reset_en_o rises. reset_en_o stays high until a clock edge samples rst_done_i=1 during the reset phase, so the phase lasts at least one cycle.
- R5: sense_i has no effect while sense_en_o=0. Holding it high through quench, hold-off and reset neither lengthens the phases nor restarts the pulse.
- R6: An edge sampling gate_i=0 puts the controller in the forced-quench state from the next cycle: quench_en_o=1, reset_en_o=0, sense_en_o=0. This takes priority over a simultaneous sense event.
- R7: An edge sampling gate_i=1 in forced quench starts a full reset phase (reset_en_o=1). No detection pulse appears on either gate edge.
- R8: det_pulse_o is high for min(PULSE_W, hold-off cycles + reset cycles) cycles after a detection. It is low whenever the pixel is armed and drops at once when the gate forces a quench.
- R9: fault_o becomes 1 after RST_TIMEOUT consecutive reset-phase cycles with rst_done_i=0. It stays at 1 until rst_n is asserted.
- R10: When the reset phase ends, the pixel is armed: sense_en_o=1, quench_en_o=0, reset_en_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_i | input | 1 | Thresholded avalanche-sense level |
| rst_done_i | input | 1 | Node-recovered comparator flag |
| gate_i | input | 1 | Gate level; low forces the pixel off |
| holdoff_i | input | HOLD_W | Hold-off length in cycles (0 acts as 1) |
| quench_en_o | output | 1 | Quench switch enable |
| reset_en_o | output | 1 | Reset switch enable |
| sense_en_o | output | 1 | Sense path enabled (pixel armed) |
| det_pulse_o | output | 1 | Detection pulse aligned to quench start |
| fault_o | output | 1 | Sticky reset-timeout fault |

## Verification
The bench sweeps hold-off values of 0, 1, short, long and 255, with reset lengths of one cycle and more. It aims at the point where the pulse stops being clipped by hold-off plus reset. A design that keeps the nominal width would let the pulse run into the armed state, and one that treats 0 as 256 would hold the pixel off far too long. Sense is held high through whole events to expose a controller that re-triggers on echoes. Gate drops during an armed sense and during hold-off, and then rises, to catch pulses produced on gate edges, a lost gate priority, or re-arming without a reset phase. A withheld recovery flag checks that the fault comes neither early nor late and that it survives the eventual recovery.

// File: rtl/pqs_pkg.sv
`timescale 1ns/1ps
package pqs_pkg;
  typedef enum logic [1:0] {
    PH_ARMED    = 2'd0,
    PH_HOLD     = 2'd1,
    PH_RECHARGE = 2'd2,
    PH_BLOCKED  = 2'd3
  } phase_t;
endpackage

// File: rtl/pqs_holdoff_timer.sv
`timescale 1ns/1ps
// Counts the hold-off window; a loaded value of 0 behaves as 1.
module pqs_holdoff_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] value_i,
  input  logic          run_i,
  output logic          done_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load_i | run_i;
    if (load_i)
      cnt_d = value_i;
    else if (run_i && (cnt_q > ONE))
      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q <= ONE);
endmodule

// File: rtl/pqs_pulse_gen.sv
`timescale 1ns/1ps
// Detection pulse: at most WIDTH cycles, and only while the pixel is busy.
module pqs_pulse_gen #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic active_i,
  output logic pulse_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] SAT = CW'(WIDTH);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] age_q, age_d;
  logic          age_en;

  always_comb begin
    age_d  = age_q;
    age_en = 1'b1;
    if (start_i)
      age_d = '0;
    else if (!active_i)
      age_d = SAT;
    else if (age_q < SAT)
      age_d = age_q + ONE;
    else
      age_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      age_q <= SAT;
    else if (age_en)
      age_q <= age_d;
  end

  assign pulse_o = active_i && (age_q < SAT);
endmodule

// File: rtl/pqs_reset_watch.sv
`timescale 1ns/1ps
// Flags a reset phase that never sees the recovery flag.
module pqs_reset_watch #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic done_i,
  output logic fault_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cyc_q, cyc_d;
  logic          fault_q, fault_d;

  always_comb begin
    cyc_d   = cyc_q;
    fault_d = fault_q;
    if (!busy_i)
      cyc_d = '0;
    else if (cyc_q < TOP)
      cyc_d = cyc_q + ONE;
    if (busy_i && !done_i && (cyc_q >= LAST))
      fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cyc_q   <= cyc_d;
      fault_q <= fault_d;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/pixel_quench_seq.sv
`timescale 1ns/1ps
module pixel_quench_seq #(
  parameter int HOLD_W      = 8,
  parameter int PULSE_W     = 4,
  parameter int RST_TIMEOUT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sense_i,
  input  logic              rst_done_i,
  input  logic              gate_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  output logic              quench_en_o,
  output logic              reset_en_o,
  output logic              sense_en_o,
  output logic              det_pulse_o,
  output logic              fault_o
);
  import pqs_pkg::*;

  localparam int SYNC_STAGES = 2;

  // Asynchronous assert, synchronous release.
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rsync_q <= '0;
    else
      rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = rsync_q[SYNC_STAGES-1];

  phase_t ph_q, ph_d;
  logic   fire, hold_done, in_hold, in_rchg, busy;

  assign in_hold = (ph_q == PH_HOLD);
  assign in_rchg = (ph_q == PH_RECHARGE);
  assign busy    = in_hold | in_rchg;
  assign fire    = (ph_q == PH_ARMED) && gate_i && sense_i;

  always_comb begin
    ph_d = ph_q;
    if (!gate_i) begin
      ph_d = PH_BLOCKED;
    end else begin
      unique case (ph_q)
        PH_ARMED:    if (sense_i)    ph_d = PH_HOLD;
        PH_HOLD:     if (hold_done)  ph_d = PH_RECHARGE;
        PH_RECHARGE: if (rst_done_i) ph_d = PH_ARMED;
        PH_BLOCKED:                  ph_d = PH_RECHARGE;
        default:                     ph_d = PH_BLOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)
      ph_q <= PH_BLOCKED;
    else
      ph_q <= ph_d;
  end

  pqs_holdoff_timer #(.CW(HOLD_W)) u_hold (
    .clk     (clk),
    .rst_n   (srst_n),
    .load_i  (fire),
    .value_i (holdoff_i),
    .run_i   (in_hold),
    .done_o  (hold_done)
  );

  pqs_pulse_gen #(.WIDTH(PULSE_W)) u_pulse (
    .clk      (clk),
    .rst_n    (srst_n),
    .start_i  (fire),
    .active_i (busy),
    .pulse_o  (det_pulse_o)
  );

  pqs_reset_watch #(.LIMIT(RST_TIMEOUT)) u_watch (
    .clk     (clk),
    .rst_n   (srst_n),
    .busy_i  (in_rchg),
    .done_i  (rst_done_i),
    .fault_o (fault_o)
  );

  assign quench_en_o = in_hold | (ph_q == PH_BLOCKED);
  assign reset_en_o  = in_rchg;
  assign sense_en_o  = (ph_q == PH_ARMED);
endmodule

// File: rtl/pqs_checker.sv
`timescale 1ns/1ps
module pqs_checker (
  input logic clk,
  input logic rst_n,
  input logic gate_i,
  input logic rst_done_i,
  input logic quench_en_o,
  input logic reset_en_o,
  input logic sense_en_o,
  input logic det_pulse_o,
  input logic fault_o
);
  assert_pulse_at_quench_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_pulse_o) |-> $rose(quench_en_o));

  assert_reset_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_en_o && !rst_done_i && gate_i) |=> reset_en_o);

  assert_sense_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (quench_en_o || reset_en_o) |-> !sense_en_o);

  assert_gate_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_i |=> (quench_en_o && !sense_en_o && !reset_en_o));

  assert_gate_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_i) || $fell(gate_i)) |=> !$rose(det_pulse_o));

  assert_pulse_off_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sense_en_o |-> !det_pulse_o);

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);

  assert_switch_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(quench_en_o && reset_en_o));
endmodule

bind pixel_quench_seq pqs_checker u_pqs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_i      (gate_i),
  .rst_done_i  (rst_done_i),
  .quench_en_o (quench_en_o),
  .reset_en_o  (reset_en_o),
  .sense_en_o  (sense_en_o),
  .det_pulse_o (det_pulse_o),
  .fault_o     (fault_o)
);

// File: tb/test_pixel_quench_seq.sv
`timescale 1ns/1ps
module test_pixel_quench_seq;
  localparam int PW  = 4;
  localparam int TMO = 32;
  localparam int NV  = 9;

  logic       clk = 1'b0;
  logic       rst_n, sense, rst_done, gate;
  logic [7:0] holdoff;
  logic       quench, rst_en, sense_en, det, fault;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pixel_quench_seq #(.HOLD_W(8), .PULSE_W(PW), .RST_TIMEOUT(TMO)) i_pixel_quench_seq (
    .clk(clk), .rst_n(rst_n), .sense_i(sense), .rst_done_i(rst_done), .gate_i(gate),
    .holdoff_i(holdoff), .quench_en_o(quench), .reset_en_o(rst_en),
    .sense_en_o(sense_en), .det_pulse_o(det), .fault_o(fault)
  );

  typedef struct packed {
    logic [7:0] hold;
    logic [7:0] rdly;
    logic       noisy;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'd0,   8'd0, 1'b0}, '{8'd1,   8'd0, 1'b0}, '{8'd2,   8'd0, 1'b0},
    '{8'd3,   8'd0, 1'b0}, '{8'd7,   8'd0, 1'b0}, '{8'd255, 8'd0, 1'b0},
    '{8'd1,   8'd5, 1'b0}, '{8'd10,  8'd0, 1'b1}, '{8'd0,   8'd3, 1'b1}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int exp_width(int h, int r);
    int tot;
    tot = ((h == 0) ? 1 : h) + r + 1;
    return (tot < PW) ? tot : PW;
  endfunction

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dc, qc, rc, seen;
    rst_n = 1'b0; sense = 1'b0; rst_done = 1'b0; gate = 1'b1; holdoff = 8'd0;
    step(); step();
    // R1 reset state
    chk("R1 quench", quench, 1);
    chk("R1 reset_en", rst_en, 0);
    chk("R1 sense_en", sense_en, 0);
    chk("R1 det", det, 0);
    chk("R1 fault", fault, 0);
    rst_n = 1'b1;
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      if (rst_en) seen = 1;
      if (sense_en) break;
      rst_done = rst_en;
      step();
    end
    rst_done = 1'b0;
    chk("R1 reset phase before arming", seen, 1);
    chk("R10 armed after start", sense_en, 1);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      holdoff = VEC[i].hold;
      sense = 1'b1;
      step();
      sense = VEC[i].noisy;
      chk("R2 pulse with quench", int'(det && quench && !sense_en), 1);
      dc = 0; qc = 0; rc = 0;
      for (int k = 0; k < 600; k++) begin
        if (sense_en) break;
        dc += det; qc += quench; rc += rst_en;
        rst_done = rst_en && (rc >= int'(VEC[i].rdly) + 1);
        step();
      end
      sense = 1'b0;
      rst_done = 1'b0;
      chk(VEC[i].noisy ? "R5 R3 hold cycles" : "R3 hold cycles", qc,
          (VEC[i].hold == 0) ? 1 : int'(VEC[i].hold));
      chk("R4 reset cycles", rc, int'(VEC[i].rdly) + 1);
      chk(VEC[i].noisy ? "R5 R8 pulse width" : "R8 pulse width", dc,
          exp_width(int'(VEC[i].hold), int'(VEC[i].rdly)));
      chk("R10 switches open when armed", int'(quench || rst_en), 0);
      step();
      chk("R8 no pulse while armed", int'(det), 0);
    end

    // Gate low with coincident sense
    gate = 1'b0; sense = 1'b1;
    step();
    chk("R6 forced quench", int'(quench && !sense_en && !rst_en), 1);
    chk("R7 no pulse on gate fall", det, 0);
    dc = 0; rc = 0;
    for (int k = 0; k < 6; k++) begin
      sense = ~sense;
      step();
      dc += det; rc += rst_en;
    end
    chk("R6 sense ignored while gated", dc + rc, 0);
    chk("R6 still quenched", quench, 1);
    gate = 1'b1; sense = 1'b0; rst_done = 1'b0;
    step();
    chk("R7 reset phase on gate rise", rst_en, 1);
    chk("R7 no pulse on gate rise", det, 0);
    rst_done = 1'b1;
    step();
    rst_done = 1'b0;
    chk("R10 armed after gate rise", sense_en, 1);

    // Gate drop during hold-off truncates the pulse
    holdoff = 8'd50; sense = 1'b1;
    step();
    sense = 1'b0;
    step(); step();
    chk("R8 pulse running", det, 1);
    gate = 1'b0;
    step();
    chk("R8 pulse cut by gate", det, 0);
    chk("R6 quench from hold", int'(quench && !rst_en), 1);
    gate = 1'b1;
    step();
    chk("R7 reset after gate in hold", int'(rst_en && !det), 1);
    rst_done = 1'b1;
    step();
    rst_done = 1'b0;
    chk("R10 armed again", sense_en, 1);

    // Reset timeout fault
    holdoff = 8'd1; sense = 1'b1;
    step();
    sense = 1'b0;
    step();
    chk("R4 reset phase begins", rst_en, 1);
    for (int k = 0; k < 20; k++) step();
    chk("R9 no early fault", fault, 0);
    chk("R4 reset held without flag", rst_en, 1);
    for (int k = 0; k < 20; k++) step();
    chk("R9 fault raised", fault, 1);
    rst_done = 1'b1;
    step();
    rst_done = 1'b0;
    chk("R10 armed after late flag", sense_en, 1);
    step();
    chk("R9 fault sticky", fault, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule